// File: doc/BRIEF.md
# Idle Depth Controller

This block steps a processor core down into one of three idle depths and back up again. Software names a depth, and the controller removes resources one per clock cycle. The shallowest depth stops only the core clock. The middle depth also stops the auxiliary clocks. The deepest depth also asserts a power-down enable for part of the core. A wake event reverses the sequence: power returns first, then the auxiliary clocks, then the core clock.

When the wake is taken, a down-counter is loaded with that depth's exit latency expressed in clock cycles. The core is declared running again only after this counter has drained and every resource has been restored. The latency is one microsecond for the two shallow depths and fifty-seven microseconds for the deep depth. It is scaled by a cycles-per-microsecond parameter.

If a wake arrives while the controller is still descending, the descent stops. The controller then climbs back from whatever depth it has reached, using that depth's latency. The current depth is reported as a 2-bit code, and a ready flag marks a completed exit.

Top module: `idle_depth_ctrl`

## Requirements
- R1: After a synchronous reset, `core_clk_en` and `aux_clk_en` are 1, `pwr_down` is 0, `state_code` is 0 (running) and `ready` is 1.
- R2: A request for level 1, sampled while `ready` is 1, clears `core_clk_en` on the next cycle. At that point `state_code` is 1 and `ready` is 0. `aux_clk_en` stays 1 and `pwr_down` stays 0.
- R3: A request for level 2 first behaves as in R2. On the following cycle it also clears `aux_clk_en`, and `state_code` becomes 2.
- R4: A request for level 3 continues one cycle further than R3. It sets `pwr_down`, and `state_code` becomes 3.
- R5: The `req_level` encoding is 1, 2 or 3 for the three depths. The value 0 is unsupported and is handled as level 1.
- R6: A request is ignored unless the block is running with `ready` at 1. A request made while asleep or while exiting leaves every output unchanged.
- R7: The cycle in which a wake is sampled changes no output. On the cycles that follow, resources are restored one per cycle, in this order: power down is released, then `aux_clk_en` is set, then `core_clk_en` is set. `state_code` drops by one at each step.
- R8: `ready` rises exactly L×`CYC_PER_US`+1 cycles after the cycle in which the wake was sampled. L is 1 for levels 1 and 2 and 57 for level 3.
- R9: A wake sampled during the descent stops it at the depth reached so far. The exit then uses that depth's latency.
- R10: A request sampled in the same cycle as a wake while running is dropped, and the block stays running and ready.
- R11: A wake while running has no effect on any output.
- R12: `pwr_down` at 1 implies `aux_clk_en` is 0, and `aux_clk_en` at 0 implies `core_clk_en` is 0. `ready` at 1 implies every resource is on and `state_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Asks to enter the idle depth given by `req_level` |
| req_level | input | 2 | Requested depth: 1, 2 or 3 (0 is handled as 1) |
| wake | input | 1 | Wake or interrupt event |
| core_clk_en | output | 1 | Core clock enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| pwr_down | output | 1 | Power-down enable for part of the core |
| state_code | output | 2 | Current depth: 0 running, 1, 2 or 3 |
| ready | output | 1 | Core is running and the exit latency has elapsed |

## Verification
Two pairs of functions can fall in the same cycle: a wake and one step of the descent, and a wake and a new request while the block is running. The bench raises a wake one and two cycles after a deep request, which catches the descent at depth 1 and at depth 2. It then expects the climb to start from that depth and the ready flag to follow that depth's shallow latency rather than the deep one. It also raises a request and a wake in the same cycle, and expects the block to stay running and ready on the next cycle.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_ENTER = 2'd1,
    PH_SLEEP = 2'd2,
    PH_EXIT  = 2'd3
  } phase_e;

  localparam logic [1:0] DEPTH_RUN = 2'd0;
  localparam logic [1:0] DEPTH_L1  = 2'd1;
  localparam logic [1:0] DEPTH_L2  = 2'd2;
  localparam logic [1:0] DEPTH_L3  = 2'd3;
endpackage

// File: rtl/idle_exit_timer.sv
module idle_exit_timer #(
  parameter int unsigned CYC_PER_US     = 10,
  parameter int unsigned LAT_SHALLOW_US = 1,
  parameter int unsigned LAT_DEEP_US    = 57
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] depth,
  output logic       zero
);
  import idle_pkg::*;

  localparam int unsigned SHALLOW_CNT = LAT_SHALLOW_US * CYC_PER_US;
  localparam int unsigned DEEP_CNT    = LAT_DEEP_US * CYC_PER_US;
  localparam int unsigned MAX_CNT     = (DEEP_CNT > SHALLOW_CNT) ? DEEP_CNT : SHALLOW_CNT;
  localparam int unsigned CW          = $clog2(MAX_CNT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  // the deep level has its own exit latency; both shallow levels share one
  always_comb begin
    if (depth == DEPTH_L3) load_val = CW'(DEEP_CNT);
    else                   load_val = CW'(SHALLOW_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1))
    else $error("exit counter skipped a step");
endmodule

// File: rtl/idle_step_fsm.sv
module idle_step_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_level,
  input  logic       wake,
  input  logic       timer_zero,
  output logic       timer_load,
  output logic [1:0] depth,
  output logic       core_en,
  output logic       aux_en,
  output logic       pwr_dn,
  output logic       ready
);
  import idle_pkg::*;

  phase_e     phase;
  logic [1:0] target;
  logic [1:0] req_tgt;

  // an unsupported level code is mapped onto the shallowest depth
  assign req_tgt    = (req_level == DEPTH_RUN) ? DEPTH_L1 : req_level;
  assign timer_load = wake && (phase == PH_ENTER || phase == PH_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_RUN;
      target  <= DEPTH_L1;
      depth   <= DEPTH_RUN;
      core_en <= 1'b1;
      aux_en  <= 1'b1;
      pwr_dn  <= 1'b0;
      ready   <= 1'b1;
    end else begin
      case (phase)
        PH_RUN: begin
          if (req_valid && !wake && ready) begin
            target  <= req_tgt;
            depth   <= DEPTH_L1;
            core_en <= 1'b0;
            ready   <= 1'b0;
            phase   <= (req_tgt == DEPTH_L1) ? PH_SLEEP : PH_ENTER;
          end
        end
        PH_ENTER: begin
          if (wake) begin
            phase <= PH_EXIT;
          end else if (depth == DEPTH_L1) begin
            aux_en <= 1'b0;
            depth  <= DEPTH_L2;
            phase  <= (target == DEPTH_L2) ? PH_SLEEP : PH_ENTER;
          end else begin
            pwr_dn <= 1'b1;
            depth  <= DEPTH_L3;
            phase  <= PH_SLEEP;
          end
        end
        PH_SLEEP: begin
          if (wake) phase <= PH_EXIT;
        end
        PH_EXIT: begin
          if (pwr_dn) begin
            pwr_dn <= 1'b0;
            depth  <= DEPTH_L2;
          end else if (!aux_en) begin
            aux_en <= 1'b1;
            depth  <= DEPTH_L1;
          end else if (!core_en) begin
            core_en <= 1'b1;
            depth   <= DEPTH_RUN;
          end else if (timer_zero) begin
            ready <= 1'b1;
            phase <= PH_RUN;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  p_gate_nesting_r12: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn |-> !aux_en) and (!aux_en |-> !core_en))
    else $error("resource gating out of nesting order");

  p_ready_all_on_r12: assert property (@(posedge clk) disable iff (rst)
    ready |-> (core_en && aux_en && !pwr_dn && depth == DEPTH_RUN))
    else $error("ready while a resource is removed");

  p_entry_from_run_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(core_en) |-> $past(ready))
    else $error("entry started outside the running state");

  p_aux_after_pwr_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(aux_en) |-> !$past(pwr_dn))
    else $error("aux clocks restored before power");

  p_core_after_aux_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(core_en) |-> $past(aux_en))
    else $error("core clock restored before aux clocks");

  p_depth_step_r2: assert property (@(posedge clk) disable iff (rst)
    (depth != $past(depth)) |->
      (int'(depth) == int'($past(depth)) + 1 || int'(depth) + 1 == int'($past(depth))))
    else $error("depth moved by more than one level");

  p_wake_blocks_req_r10: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && wake) |=> ready)
    else $error("request taken together with a wake");
endmodule

// File: rtl/idle_depth_ctrl.sv
module idle_depth_ctrl #(
  parameter int unsigned CYC_PER_US     = 10,
  parameter int unsigned LAT_SHALLOW_US = 1,
  parameter int unsigned LAT_DEEP_US    = 57
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_level,
  input  logic       wake,
  output logic       core_clk_en,
  output logic       aux_clk_en,
  output logic       pwr_down,
  output logic [1:0] state_code,
  output logic       ready
);
  logic       timer_load;
  logic       timer_zero;
  logic [1:0] depth;

  idle_step_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_level  (req_level),
    .wake       (wake),
    .timer_zero (timer_zero),
    .timer_load (timer_load),
    .depth      (depth),
    .core_en    (core_clk_en),
    .aux_en     (aux_clk_en),
    .pwr_dn     (pwr_down),
    .ready      (ready)
  );

  idle_exit_timer #(
    .CYC_PER_US     (CYC_PER_US),
    .LAT_SHALLOW_US (LAT_SHALLOW_US),
    .LAT_DEEP_US    (LAT_DEEP_US)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (timer_load),
    .depth (depth),
    .zero  (timer_zero)
  );

  assign state_code = depth;

  p_ready_after_timer_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(timer_zero))
    else $error("ready raised before the exit latency elapsed");

  p_wake_in_run_r11: assert property (@(posedge clk) disable iff (rst)
    (ready && !req_valid) |=> ready)
    else $error("running state left without a request");
endmodule

// File: tb/sim_idle_depth_ctrl.sv
module sim_idle_depth_ctrl;
  localparam int CYC = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] req_level;
  logic       wake;
  logic       core_clk_en, aux_clk_en, pwr_down, ready;
  logic [1:0] state_code;

  always #10 clk = ~clk;

  idle_depth_ctrl #(.CYC_PER_US(CYC), .LAT_SHALLOW_US(1), .LAT_DEEP_US(57)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level), .wake(wake),
    .core_clk_en(core_clk_en), .aux_clk_en(aux_clk_en), .pwr_down(pwr_down),
    .state_code(state_code), .ready(ready)
  );

  typedef struct {
    int         at;
    logic       ce;
    logic       ae;
    logic       pd;
    logic [1:0] code;
    logic       rdy;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic ex(input int at, input bit ce, input bit ae, input bit pd,
                    input int code, input bit rdy, input string tag);
    exp_t e;
    e.at = at; e.ce = ce; e.ae = ae; e.pd = pd;
    e.code = 2'(code); e.rdy = rdy; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: pops every expected item whose cycle has come
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (e.at != cyc || core_clk_en !== e.ce || aux_clk_en !== e.ae ||
          pwr_down !== e.pd || state_code !== e.code || ready !== e.rdy) begin
        fails++;
        $display("FAIL %s cyc %0d: got ce=%b ae=%b pd=%b code=%0d rdy=%b, expected ce=%b ae=%b pd=%b code=%0d rdy=%b",
                 e.tag, cyc, core_clk_en, aux_clk_en, pwr_down, state_code, ready,
                 e.ce, e.ae, e.pd, e.code, e.rdy);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    int t;
    rst = 1'b1; req_valid = 1'b0; req_level = 2'd0; wake = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    ex(cyc + 1, 1, 1, 0, 0, 1, "R1");
    step(); step();

    // R11: wake while running changes nothing
    wake = 1'b1; t = cyc;
    ex(t + 1, 1, 1, 0, 0, 1, "R11");
    step(); wake = 1'b0; step();

    // R10: request together with wake is dropped
    req_valid = 1'b1; req_level = 2'd3; wake = 1'b1; t = cyc;
    ex(t + 1, 1, 1, 0, 0, 1, "R10");
    ex(t + 2, 1, 1, 0, 0, 1, "R10");
    step(); req_valid = 1'b0; wake = 1'b0; step(); step();

    // R2 / R8: level 1 round trip
    req_valid = 1'b1; req_level = 2'd1; t = cyc;
    ex(t + 1, 0, 1, 0, 1, 0, "R2");
    ex(t + 2, 0, 1, 0, 1, 0, "R2");
    step(); req_valid = 1'b0; repeat (3) step();
    wake = 1'b1; t = cyc;
    ex(t + 1, 0, 1, 0, 1, 0, "R7");
    ex(t + 2, 1, 1, 0, 0, 0, "R7");
    ex(t + 1 + CYC, 1, 1, 0, 0, 0, "R8");
    ex(t + 2 + CYC, 1, 1, 0, 0, 1, "R8");
    step(); wake = 1'b0;
    while (cyc < t + 3 + CYC) step();

    // R3: level 2 round trip
    req_valid = 1'b1; req_level = 2'd2; t = cyc;
    ex(t + 1, 0, 1, 0, 1, 0, "R3");
    ex(t + 2, 0, 0, 0, 2, 0, "R3");
    ex(t + 3, 0, 0, 0, 2, 0, "R3");
    step(); req_valid = 1'b0; repeat (3) step();
    wake = 1'b1; t = cyc;
    ex(t + 1, 0, 0, 0, 2, 0, "R7");
    ex(t + 2, 0, 1, 0, 1, 0, "R7");
    ex(t + 3, 1, 1, 0, 0, 0, "R7");
    ex(t + 1 + CYC, 1, 1, 0, 0, 0, "R8");
    ex(t + 2 + CYC, 1, 1, 0, 0, 1, "R8");
    step(); wake = 1'b0;
    while (cyc < t + 3 + CYC) step();

    // R5: level code 0 acts as level 1
    req_valid = 1'b1; req_level = 2'd0; t = cyc;
    ex(t + 1, 0, 1, 0, 1, 0, "R5");
    ex(t + 2, 0, 1, 0, 1, 0, "R5");
    ex(t + 3, 0, 1, 0, 1, 0, "R5");
    step(); req_valid = 1'b0; repeat (3) step();
    wake = 1'b1; t = cyc;
    ex(t + 2 + CYC, 1, 1, 0, 0, 1, "R5");
    step(); wake = 1'b0;
    while (cyc < t + 3 + CYC) step();

    // R4 / R6 / R7 / R8: level 3 round trip
    req_valid = 1'b1; req_level = 2'd3; t = cyc;
    ex(t + 1, 0, 1, 0, 1, 0, "R4");
    ex(t + 2, 0, 0, 0, 2, 0, "R4");
    ex(t + 3, 0, 0, 1, 3, 0, "R4");
    step(); req_valid = 1'b0; step(); step();
    req_valid = 1'b1; req_level = 2'd1;
    ex(cyc + 1, 0, 0, 1, 3, 0, "R6");
    step(); req_valid = 1'b0; step();
    wake = 1'b1; t = cyc;
    ex(t + 1, 0, 0, 1, 3, 0, "R7");
    ex(t + 2, 0, 0, 0, 2, 0, "R7");
    ex(t + 3, 0, 1, 0, 1, 0, "R7");
    ex(t + 4, 1, 1, 0, 0, 0, "R7");
    step(); wake = 1'b0;
    while (cyc < t + 5) step();
    req_valid = 1'b1; req_level = 2'd2;
    ex(t + 6, 1, 1, 0, 0, 0, "R6");
    step(); req_valid = 1'b0;
    ex(t + 1 + 57 * CYC, 1, 1, 0, 0, 0, "R8");
    ex(t + 2 + 57 * CYC, 1, 1, 0, 0, 1, "R8");
    while (cyc < t + 3 + 57 * CYC) step();

    // R9: wake one cycle into a deep descent (depth 1 reached)
    req_valid = 1'b1; req_level = 2'd3; t = cyc;
    ex(t + 1, 0, 1, 0, 1, 0, "R9");
    step(); req_valid = 1'b0; wake = 1'b1;
    ex(t + 2, 0, 1, 0, 1, 0, "R9");
    ex(t + 3, 1, 1, 0, 0, 0, "R9");
    ex(t + 12, 1, 1, 0, 0, 0, "R9");
    ex(t + 13, 1, 1, 0, 0, 1, "R9");
    step(); wake = 1'b0;
    while (cyc < t + 14) step();

    // R9: wake two cycles into a deep descent (depth 2 reached)
    req_valid = 1'b1; req_level = 2'd3; t = cyc;
    ex(t + 1, 0, 1, 0, 1, 0, "R9");
    ex(t + 2, 0, 0, 0, 2, 0, "R9");
    step(); req_valid = 1'b0; step(); wake = 1'b1;
    ex(t + 3, 0, 0, 0, 2, 0, "R9");
    ex(t + 4, 0, 1, 0, 1, 0, "R9");
    ex(t + 5, 1, 1, 0, 0, 0, "R9");
    ex(t + 13, 1, 1, 0, 0, 0, "R9");
    ex(t + 14, 1, 1, 0, 0, 1, "R9");
    step(); wake = 1'b0;
    while (cyc < t + 16) step();

    done = 1;
    finish_run();
  end
endmodule